// File: doc/BRIEF.md
# Sequential Slice Read Sequencer

This block drives the timing of a full read of one bit slice in a virtual-ground memory array. Reads are not random access: every slice is sensed in one fixed order of four steps, each covering a pair of cells. The two right-side steps come first and the two left-side steps follow. The drain main bit line is kept as long as possible, so that the leakage path through neighbouring cells is the same for every sense. A pre-charge phase runs only when the drain line is about to change. After the last step the slice is discharged, so that the next read starts from the same initial conditions.

Each step runs the sense amplifier through three timed phases. Offset cancellation comes first, then initialization, in which the sense input is pulled to ground, and then integration. The comparator output is sampled at the end of integration and presented with a one-cycle valid pulse tagged with the step number. Every phase length is a cycle count taken from a configuration input. A start request that arrives while a slice is in progress is remembered and served as soon as the discharge ends.

Top module: `slice_read_seq`

## Requirements
- R1: After reset, busy, all five phase strobes and rd_valid are low, and step_idx is 0.
- R2: A start pulse while idle makes pre_chg high on the next cycle with step_idx 0. step_idx then walks 0, 1, 2, 3 once per slice and returns to 0 when idle.
- R3: side_left is 0 for steps 0 and 1 and 1 for steps 2 and 3. drain_sel is 0 for steps 0 and 1 and 1 for steps 2 and 3. pair_sel is 0, 1, 1, 0 for steps 0 to 3.
- R4: A pre-charge phase comes before step 0 and before step 2, where the drain line changes. Steps 1 and 3 go from the previous integrate phase straight to offset cancel.
- R5: Every step runs ofc_en, then init_en, then integ_en. At most one strobe out of pre_chg, ofc_en, init_en, integ_en and dis_chg is high in any cycle.
- R6: Each phase lasts as many cycles as its cfg input holds, read when the phase is entered. A value of 0 counts as 1.
- R7: sa_in is sampled in the last integ_en cycle of a step. On the next cycle rd_valid is high for one cycle, with rd_step equal to that step and rd_data equal to the sample.
- R8: After the integration of step 3, dis_chg is high for the configured length. The block then returns to idle.
- R9: Start pulses seen while busy are merged into one pending request. That request makes the block enter pre-charge right after the discharge, with no idle cycle between.
- R10: busy is high exactly when one of the five phase strobes is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to read one slice |
| cfg_pre | input | LEN_W | Pre-charge length in cycles |
| cfg_ofc | input | LEN_W | Offset-cancel length in cycles |
| cfg_init | input | LEN_W | Initialization length in cycles |
| cfg_integ | input | LEN_W | Integration length in cycles |
| cfg_dis | input | LEN_W | Discharge length in cycles |
| sa_in | input | DATA_W | Comparator outputs of the sense amplifiers |
| busy | output | 1 | A slice read is in progress |
| pre_chg | output | 1 | Pre-charge strobe |
| ofc_en | output | 1 | Offset-cancel strobe |
| init_en | output | 1 | Initialization strobe |
| integ_en | output | 1 | Integration strobe |
| dis_chg | output | 1 | End-of-slice discharge strobe |
| step_idx | output | 2 | Current step number |
| side_left | output | 1 | Left-side bits are being sensed |
| drain_sel | output | 1 | Selected drain main bit line |
| pair_sel | output | 1 | Selected cell pair |
| rd_valid | output | 1 | One-cycle pulse with sensed data |
| rd_step | output | 2 | Step number of rd_data |
| rd_data | output | DATA_W | Sensed data of one step |

## Verification
The assertions check on every cycle that the strobes exclude one another and agree with busy, that the phases follow one another in order, that the drain line changes only during pre-charge, and that every valid pulse comes right after an integration and, for step 3, lines up with the discharge. The exact phase lengths, the zero-as-one rule, the step-to-line mapping, the captured data values and the merging of starts that arrive while busy show only in the bench scenarios. There a behavioural model follows every cycle under several length settings and back-to-back requests.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int NUM_STEPS = 4;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_OFC   = 3'd2,
        PH_INIT  = 3'd3,
        PH_INTEG = 3'd4,
        PH_DIS   = 3'd5
    } srs_phase_e;
endpackage

// File: rtl/srs_step_map.sv
module srs_step_map
    import srs_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output logic              side_left,
    output logic              drain,
    output logic              pair,
    output logic              need_pre
);
    logic [STEP_W-1:0] prev_step;
    logic              prev_drain;

    always_comb begin
        // right-side steps use drain line 0, left-side steps use drain line 1
        side_left  = step[STEP_W-1];
        drain      = step[STEP_W-1];
        // walk out across the pairs and back again
        pair       = step[0] ^ step[STEP_W-1];
        prev_step  = step - 1'b1;
        prev_drain = prev_step[STEP_W-1];
        // the first step always follows a discharged slice
        need_pre   = (step == '0) || (prev_drain != drain);
    end
endmodule

// File: rtl/srs_len_pick.sv
module srs_len_pick
    import srs_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  srs_phase_e       ph,
    input  logic [LEN_W-1:0] cfg_pre,
    input  logic [LEN_W-1:0] cfg_ofc,
    input  logic [LEN_W-1:0] cfg_init,
    input  logic [LEN_W-1:0] cfg_integ,
    input  logic [LEN_W-1:0] cfg_dis,
    output logic [LEN_W-1:0] load
);
    logic [LEN_W-1:0] len;

    always_comb begin
        unique case (ph)
            PH_PRE:   len = cfg_pre;
            PH_OFC:   len = cfg_ofc;
            PH_INIT:  len = cfg_init;
            PH_INTEG: len = cfg_integ;
            PH_DIS:   len = cfg_dis;
            default:  len = '0;
        endcase
        // the counter runs from load down to zero, so a zero length acts as one
        load = (len == '0) ? '0 : len - 1'b1;
    end
endmodule

// File: rtl/srs_sense_capture.sv
module srs_sense_capture
    import srs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] sa_in,
    output logic              valid,
    output logic [STEP_W-1:0] vstep,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [STEP_W-1:0] step;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = cap;
        if (cap) begin
            c_d.step = step;
            c_d.data = sa_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign valid = c_q.valid;
    assign vstep = c_q.step;
    assign data  = c_q.data;
endmodule

// File: rtl/slice_read_seq.sv
module slice_read_seq
    import srs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_pre,
    input  logic [LEN_W-1:0]  cfg_ofc,
    input  logic [LEN_W-1:0]  cfg_init,
    input  logic [LEN_W-1:0]  cfg_integ,
    input  logic [LEN_W-1:0]  cfg_dis,
    input  logic [DATA_W-1:0] sa_in,
    output logic              busy,
    output logic              pre_chg,
    output logic              ofc_en,
    output logic              init_en,
    output logic              integ_en,
    output logic              dis_chg,
    output logic [1:0]        step_idx,
    output logic              side_left,
    output logic              drain_sel,
    output logic              pair_sel,
    output logic              rd_valid,
    output logic [1:0]        rd_step,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        srs_phase_e        ph;
        logic [LEN_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
        logic              pend;
    } seq_t;

    seq_t s_d, s_q;
    logic              cap;
    logic [LEN_W-1:0]  load;
    logic [STEP_W-1:0] step_nx;
    logic              nx_side, nx_drain, nx_pair, nx_need_pre;

    assign step_nx = s_q.step + 1'b1;

    srs_step_map u_cur_map (
        .step      (s_q.step),
        .side_left (side_left),
        .drain     (drain_sel),
        .pair      (pair_sel),
        .need_pre  ()
    );

    srs_step_map u_nxt_map (
        .step      (step_nx),
        .side_left (nx_side),
        .drain     (nx_drain),
        .pair      (nx_pair),
        .need_pre  (nx_need_pre)
    );

    srs_len_pick #(.LEN_W(LEN_W)) u_len (
        .ph        (s_d.ph),
        .cfg_pre   (cfg_pre),
        .cfg_ofc   (cfg_ofc),
        .cfg_init  (cfg_init),
        .cfg_integ (cfg_integ),
        .cfg_dis   (cfg_dis),
        .load      (load)
    );

    // next state: phase, step and pending request; the counter is loaded afterwards
    seq_t s_n;
    logic enter;

    always_comb begin
        s_n   = s_q;
        enter = 1'b0;
        cap   = 1'b0;
        if (s_q.ph != PH_IDLE && start) s_n.pend = 1'b1;
        if (s_q.ph == PH_IDLE) begin
            if (start) begin
                s_n.ph   = PH_PRE;
                s_n.step = '0;
                enter    = 1'b1;
            end
        end else if (s_q.cnt != '0) begin
            s_n.cnt = s_q.cnt - 1'b1;
        end else begin
            enter = 1'b1;
            unique case (s_q.ph)
                PH_PRE:  s_n.ph = PH_OFC;
                PH_OFC:  s_n.ph = PH_INIT;
                PH_INIT: s_n.ph = PH_INTEG;
                PH_INTEG: begin
                    cap = 1'b1;
                    if (s_q.step == LAST_STEP) begin
                        s_n.ph = PH_DIS;
                    end else begin
                        s_n.step = step_nx;
                        s_n.ph   = nx_need_pre ? PH_PRE : PH_OFC;
                    end
                end
                PH_DIS: begin
                    s_n.step = '0;
                    s_n.ph   = (s_q.pend || start) ? PH_PRE : PH_IDLE;
                    s_n.pend = 1'b0;
                end
                default: s_n.ph = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        s_d = s_n;
        if (enter) s_d.cnt = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cnt: '0, step: '0, pend: 1'b0};
        else        s_q <= s_d;
    end

    srs_sense_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .step  (s_q.step),
        .sa_in (sa_in),
        .valid (rd_valid),
        .vstep (rd_step),
        .data  (rd_data)
    );

    assign busy     = (s_q.ph != PH_IDLE);
    assign pre_chg  = (s_q.ph == PH_PRE);
    assign ofc_en   = (s_q.ph == PH_OFC);
    assign init_en  = (s_q.ph == PH_INIT);
    assign integ_en = (s_q.ph == PH_INTEG);
    assign dis_chg  = (s_q.ph == PH_DIS);
    assign step_idx = s_q.step;
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       pre_chg,
    input logic       ofc_en,
    input logic       init_en,
    input logic       integ_en,
    input logic       dis_chg,
    input logic       drain_sel,
    input logic       rd_valid,
    input logic [1:0] rd_step
);
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_chg, ofc_en, init_en, integ_en, dis_chg}));

    a_r10_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (pre_chg | ofc_en | init_en | integ_en | dis_chg));

    a_r5_ofc_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        ofc_en |=> (ofc_en || init_en));

    a_r5_init_to_integ: assert property (@(posedge clk) disable iff (!rst_n)
        init_en |=> (init_en || integ_en));

    a_r4_pre_to_ofc: assert property (@(posedge clk) disable iff (!rst_n)
        pre_chg |=> (pre_chg || ofc_en));

    a_r4_drain_move: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(drain_sel)) |-> pre_chg);

    a_r7_valid_after_integ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(integ_en) && !integ_en));

    a_r8_last_then_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_step == 2'd3) |-> dis_chg);

    a_r9_dis_exit: assert property (@(posedge clk) disable iff (!rst_n)
        dis_chg |=> (dis_chg || pre_chg || !busy));
endmodule

bind slice_read_seq srs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pre_chg   (pre_chg),
    .ofc_en    (ofc_en),
    .init_en   (init_en),
    .integ_en  (integ_en),
    .dis_chg   (dis_chg),
    .drain_sel (drain_sel),
    .rd_valid  (rd_valid),
    .rd_step   (rd_step)
);

// File: tb/slice_read_seq_test.sv
module slice_read_seq_test;
    localparam int DW = 8;
    localparam int LW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] cfg_pre = 6'd2, cfg_ofc = 6'd1, cfg_init = 6'd2, cfg_integ = 6'd3, cfg_dis = 6'd2;
    logic [DW-1:0] sa_in = 8'h5A;
    logic          busy, pre_chg, ofc_en, init_en, integ_en, dis_chg;
    logic [1:0]    step_idx, rd_step;
    logic          side_left, drain_sel, pair_sel, rd_valid;
    logic [DW-1:0] rd_data;

    slice_read_seq #(.DATA_W(DW), .LEN_W(LW)) uut (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // behavioural reference: 0 idle, 1 pre, 2 ofc, 3 init, 4 integ, 5 dis
    int m_ph = 0, m_rem = 0, m_step = 0;
    bit m_pend = 0, m_vld = 0;
    int m_vstep = 0, m_vdata = 0;

    function automatic int eff(int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int len_of(int p);
        case (p)
            1: return eff(int'(cfg_pre));
            2: return eff(int'(cfg_ofc));
            3: return eff(int'(cfg_init));
            4: return eff(int'(cfg_integ));
            default: return eff(int'(cfg_dis));
        endcase
    endfunction

    task automatic model_step();
        int np;
        m_vld = 0;
        if (m_ph != 0 && start) m_pend = 1;
        if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_step = 0; m_rem = len_of(1); end
        end else if (m_rem > 1) begin
            m_rem--;
        end else begin
            np = 0;
            case (m_ph)
                1: np = 2;
                2: np = 3;
                3: np = 4;
                4: begin
                    m_vld = 1; m_vstep = m_step; m_vdata = int'(sa_in);
                    if (m_step == 3) np = 5;
                    else begin m_step++; np = (m_step == 2) ? 1 : 2; end
                end
                default: begin
                    m_step = 0;
                    np = (m_pend || start) ? 1 : 0;
                    m_pend = 0;
                end
            endcase
            m_ph = np;
            if (np != 0) m_rem = len_of(np);
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R10", "busy", int'(busy), int'(m_ph != 0));
        chk("R5", "ofc_en", int'(ofc_en), int'(m_ph == 2));
        chk("R5", "init_en", int'(init_en), int'(m_ph == 3));
        chk("R5", "integ_en", int'(integ_en), int'(m_ph == 4));
        chk("R4", "pre_chg", int'(pre_chg), int'(m_ph == 1));
        chk("R8", "dis_chg", int'(dis_chg), int'(m_ph == 5));
        chk("R2", "step_idx", int'(step_idx), m_step);
        chk("R3", "side_left", int'(side_left), int'(m_step >= 2));
        chk("R3", "drain_sel", int'(drain_sel), int'(m_step >= 2));
        chk("R3", "pair_sel", int'(pair_sel), int'(m_step == 1 || m_step == 2));
        chk("R7", "rd_valid", int'(rd_valid), int'(m_vld));
        if (m_vld) begin
            chk("R7", "rd_step", int'(rd_step), m_vstep);
            chk("R7", "rd_data", int'(rd_data), m_vdata);
        end
    endtask

    int busy_cnt = 0;

    task automatic tick();
        if (!done) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (busy) busy_cnt++;
            compare_all();
            sa_in = sa_in * 8'd5 + 8'd3;
        end
    endtask

    task automatic run_until_idle();
        int guard = 0;
        while ((busy || m_ph != 0) && guard < 2000) begin tick(); guard++; end
        tick();
    endtask

    task automatic one_slice(int p, int o, int i, int g, int d);
        int expect_len;
        cfg_pre = LW'(p); cfg_ofc = LW'(o); cfg_init = LW'(i); cfg_integ = LW'(g); cfg_dis = LW'(d);
        busy_cnt = 0;
        start = 1'b1; tick(); start = 1'b0;
        run_until_idle();
        expect_len = 2 * eff(p) + 4 * (eff(o) + eff(i) + eff(g)) + eff(d);
        chk("R6", "busy cycles per slice", busy_cnt, expect_len);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "strobes at reset", int'({pre_chg, ofc_en, init_en, integ_en, dis_chg}), 0);
        chk("R1", "rd_valid at reset", int'(rd_valid), 0);
        chk("R1", "step_idx at reset", int'(step_idx), 0);
        rst_n = 1'b1;
        tick(); tick();

        // R2: start goes to pre-charge on the next cycle
        cfg_pre = 6'd3;
        start = 1'b1; tick(); start = 1'b0;
        chk("R2", "pre_chg after start", int'(pre_chg), 1);
        chk("R2", "step 0 after start", int'(step_idx), 0);
        run_until_idle();

        // R6: several length settings, including zero lengths
        one_slice(1, 1, 1, 1, 1);
        one_slice(0, 0, 0, 0, 0);
        one_slice(4, 2, 3, 5, 6);
        one_slice(2, 7, 1, 2, 3);

        // R9: extra starts while busy merge into one request, no idle gap
        cfg_pre = 6'd2; cfg_ofc = 6'd1; cfg_init = 6'd1; cfg_integ = 6'd2; cfg_dis = 6'd2;
        busy_cnt = 0;
        start = 1'b1; tick(); start = 1'b0;
        repeat (3) tick();
        start = 1'b1; tick(); tick(); start = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        run_until_idle();
        chk("R9", "busy cycles for two merged slices", busy_cnt, 2 * (2 * 2 + 4 * (1 + 1 + 2) + 2));

        // R9: start held high keeps slices back to back
        busy_cnt = 0;
        start = 1'b1;
        repeat (60) tick();
        start = 1'b0;
        run_until_idle();
        chk("R9", "busy never dropped while start held", int'(busy_cnt >= 60), 1);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule